// File: doc/BRIEF.md
# ECP Forward-Channel Byte Receiver

This block is the receiving end of an ECP-mode parallel-port link on the peripheral side. The host presents bytes on eight data lines. It frames each byte with an active-low strobe and marks its type with the level of an active-low auto-feed line. The receiver resynchronises these host lines into its own clock domain and answers each strobe with a busy handshake. It captures the byte when the host releases the strobe and sorts it into a data byte or a command byte.

Command bytes never reach the output. A command byte with its top bit set selects a 7-bit channel, and every later data byte carries that channel as its tag. A command byte with its top bit clear holds a repeat count. The receiver then expands the next data byte in hardware into count-plus-one copies. The result leaves the block as a valid/ready byte stream. The busy line stays high until the stream has taken every copy, so a downstream stall holds the host off without any buffering.

Top module: `ecp_fwd_rx`

## Requirements
- R1: After reset, periph_busy is low, out_valid is low, and the channel tag used for data is 0.
- R2: When host_strobe_n falls while periph_busy is low, periph_busy goes high at the third rising clock edge after the fall.
- R3: The byte taken is the value on host_data when host_strobe_n rises; the value present when the strobe fell has no effect.
- R4: A byte taken with host_autofd_n high is a data byte. With no repeat count pending, it appears once on out_data, tagged on out_chan with the current channel.
- R5: A byte taken with host_autofd_n low and bit 7 set loads bits 6:0 as the channel for all following data bytes.
- R6: A byte taken with host_autofd_n low and bit 7 clear is a repeat count N in bits 6:0. The next data byte appears N+1 times (N = 0 gives one copy, N = 127 gives 128). The count then clears, so later data bytes appear once.
- R7: When a second repeat-count command arrives before any data byte, it replaces the first.
- R8: Command bytes produce no output beat.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_chan hold their values.
- R10: periph_busy stays high while an output beat is pending or copies remain. It returns low only after the last copy is accepted and host_strobe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_strobe_n | input | 1 | Host strobe, low while the data lines carry a byte |
| host_autofd_n | input | 1 | Host byte type: high for data, low for command |
| host_data | input | 8 | Host data lines |
| periph_busy | output | 1 | Busy handshake back to the host |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Output data byte |
| out_chan | output | 7 | Channel tag of the output byte |

## Verification
A channel register left wrong shows on out_chan with the very next data beat. A lost or stale repeat count shows as a wrong number of copies, which the bench sees when the stream drains. A busy flag that clears too early lets the host send a new byte over a pending copy, which shows as a missing or out-of-order beat. A busy flag that never clears stalls the host handshake and shows within a bounded wait. The strobe-to-busy latency is fixed by the two-stage synchroniser and the edge register, so the bench checks it to the exact cycle on every byte.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;
  localparam int DATA_W = 8;
  localparam int CHAN_W = DATA_W - 1;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CHAN_W-1:0] chan_t;

  // top bit of a command byte separates channel selects from repeat counts
  function automatic logic is_chan_cmd(input byte_t b);
    return b[DATA_W-1];
  endfunction

  function automatic chan_t low_field(input byte_t b);
    return b[CHAN_W-1:0];
  endfunction
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else if (g == 0) stage_q[g] <= d;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ecp_strobe_edge.sv
module ecp_strobe_edge
  import ecp_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_strobe_n,
  input  logic  s_autofd_n,
  input  byte_t s_data,
  input  logic  engine_idle,
  output logic  busy,
  output logic  strobe_fall,
  output logic  byte_evt,
  output logic  byte_is_cmd,
  output byte_t byte_val
);
  logic strobe_q;
  logic busy_q;
  logic strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= s_strobe_n;
  end

  assign strobe_fall = strobe_q & ~s_strobe_n;
  assign strobe_rise = ~strobe_q & s_strobe_n;

  // byte is taken on the release edge of the synchronised strobe
  assign byte_evt    = strobe_rise;
  assign byte_is_cmd = ~s_autofd_n;
  assign byte_val    = s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else if (strobe_fall)
      busy_q <= 1'b1;
    else if (busy_q && s_strobe_n && !strobe_rise && engine_idle)
      busy_q <= 1'b0;
  end

  assign busy = busy_q;
endmodule

// File: rtl/ecp_rle_engine.sv
module ecp_rle_engine
  import ecp_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byte_evt,
  input  logic  byte_is_cmd,
  input  byte_t byte_val,
  input  logic  out_ready,
  output logic  out_valid,
  output byte_t out_data,
  output chan_t out_chan,
  output logic  engine_idle,
  output logic  rep_pending
);
  chan_t cur_chan;
  chan_t rle_cnt;
  logic  rle_armed;
  chan_t rep_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      cur_chan  <= '0;
      rle_cnt   <= '0;
      rle_armed <= 1'b0;
      rep_left  <= '0;
    end else begin
      if (out_valid && out_ready) begin
        if (rep_left != '0) rep_left <= rep_left - 1'b1;
        else                out_valid <= 1'b0;
      end
      if (byte_evt) begin
        if (byte_is_cmd) begin
          if (is_chan_cmd(byte_val)) begin
            cur_chan <= low_field(byte_val);
          end else begin
            rle_cnt   <= low_field(byte_val);
            rle_armed <= 1'b1;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= byte_val;
          out_chan  <= cur_chan;
          rep_left  <= rle_armed ? rle_cnt : '0;
          rle_armed <= 1'b0;
        end
      end
    end
  end

  assign rep_pending = (rep_left != '0);
  assign engine_idle = ~out_valid;
endmodule

// File: rtl/ecp_fwd_rx.sv
module ecp_fwd_rx
  import ecp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_n,
  input  logic              host_autofd_n,
  input  logic [DATA_W-1:0] host_data,
  output logic              periph_busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CHAN_W-1:0] out_chan
);
  localparam int SYNC_W = DATA_W + 2;

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic  s_strobe_n;
  logic  s_autofd_n;
  byte_t s_data;

  logic  strobe_fall;
  logic  byte_evt;
  logic  byte_is_cmd;
  byte_t byte_val;
  logic  engine_idle;
  logic  rep_pending;

  assign raw_bus = {host_strobe_n, host_autofd_n, host_data};

  ecp_sync #(
    .W(SYNC_W), .STAGES(2), .RST_VAL({2'b11, {DATA_W{1'b0}}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign s_strobe_n = sync_bus[SYNC_W-1];
  assign s_autofd_n = sync_bus[SYNC_W-2];
  assign s_data     = sync_bus[DATA_W-1:0];

  ecp_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .s_strobe_n(s_strobe_n), .s_autofd_n(s_autofd_n), .s_data(s_data),
    .engine_idle(engine_idle), .busy(periph_busy),
    .strobe_fall(strobe_fall), .byte_evt(byte_evt),
    .byte_is_cmd(byte_is_cmd), .byte_val(byte_val)
  );

  ecp_rle_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .byte_evt(byte_evt), .byte_is_cmd(byte_is_cmd), .byte_val(byte_val),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .engine_idle(engine_idle), .rep_pending(rep_pending)
  );
endmodule

// File: rtl/ecp_fwd_rx_chk.sv
module ecp_fwd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periph_busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [6:0] out_chan,
  input logic       strobe_fall,
  input logic       byte_evt,
  input logic       byte_is_cmd,
  input logic       rep_pending
);
  AST_FALL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall |=> periph_busy); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan)); // R9

  AST_REPEAT_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && rep_pending |=> out_valid && $stable(out_data)); // R6

  AST_CMD_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt && byte_is_cmd |=> !out_valid); // R8

  AST_BUSY_COVERS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || rep_pending) |-> periph_busy); // R10
endmodule

bind ecp_fwd_rx ecp_fwd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .periph_busy(periph_busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_chan(out_chan), .strobe_fall(strobe_fall), .byte_evt(byte_evt),
  .byte_is_cmd(byte_is_cmd), .rep_pending(rep_pending)
);

// File: tb/tb_ecp_fwd_rx.sv
module tb_ecp_fwd_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_strobe_n = 1'b1;
  logic       host_autofd_n = 1'b1;
  logic [7:0] host_data = 8'h00;
  logic       periph_busy;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic [6:0] out_chan;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int ready_mode = 0;
  int cyc = 0;

  logic [14:0] exp_q [1024];
  int wr_idx = 0;
  int rd_idx = 0;
  logic [6:0] m_chan = '0;
  logic [6:0] m_cnt = '0;
  bit m_armed = 0;

  always #4 clk = ~clk;

  ecp_fwd_rx dut (
    .clk(clk), .rst_n(rst_n), .host_strobe_n(host_strobe_n),
    .host_autofd_n(host_autofd_n), .host_data(host_data),
    .periph_busy(periph_busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan)
  );

  // bit 8: 1 = command cycle, 0 = data cycle
  localparam int NV = 16;
  localparam logic [8:0] VEC [NV] = '{
    9'h185, 9'h011, 9'h022, 9'h102, 9'h0A5, 9'h03C, 9'h1FF, 9'h100,
    9'h000, 9'h105, 9'h101, 9'h077, 9'h17F, 9'h0E1, 9'h180, 9'h05A
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // independent model of the expected stream
  task automatic model(input bit cmd, input logic [7:0] b);
    if (cmd) begin
      if (b[7]) m_chan = b[6:0];
      else begin m_cnt = b[6:0]; m_armed = 1; end
    end else begin
      for (int k = 0; k <= (m_armed ? int'(m_cnt) : 0); k++) begin
        exp_q[wr_idx] = {m_chan, b};
        wr_idx++;
      end
      m_armed = 0;
      m_cnt = '0;
    end
  endtask

  task automatic send(input bit cmd, input logic [7:0] b, input bit wait_release);
    int n;
    model(cmd, b);
    @(negedge clk);
    host_autofd_n = ~cmd;
    host_data = ~b;          // junk while strobe falls, R3
    host_strobe_n = 1'b0;
    n = 0;
    while (!periph_busy && n < 50) begin @(negedge clk); n++; end
    check(n == 3, "R2", "strobe-to-busy cycles", n, 3);
    host_data = b;
    repeat (2) @(negedge clk);
    host_strobe_n = 1'b1;
    if (wait_release) begin
      n = 0;
      while (periph_busy && n < 3000) begin @(negedge clk); n++; end
      check(!periph_busy, "R10", "busy release after drain", periph_busy, 0);
    end
  endtask

  // output ready pattern
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (ready_mode == 0) out_ready = 1'b1;
      else if (ready_mode == 1) out_ready = (cyc % 3) != 0;
      else out_ready = 1'b0;
    end
  end

  // output monitor: compare each accepted beat with the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (!periph_busy) check(0, "R10", "busy low with beat pending", 0, 1);
        if (out_ready) begin
          if (rd_idx >= wr_idx) check(0, "R8", "unexpected beat", {out_chan, out_data}, 0);
          else begin
            check(out_data == exp_q[rd_idx][7:0], "R4 R6 R3", "beat data",
                  out_data, exp_q[rd_idx][7:0]);
            check(out_chan == exp_q[rd_idx][14:8], "R5", "beat channel",
                  out_chan, exp_q[rd_idx][14:8]);
          end
          rd_idx++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(periph_busy == 0, "R1", "busy after reset", periph_busy, 0);
    check(out_valid == 0, "R1", "valid after reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(periph_busy == 0 && out_valid == 0, "R1", "idle after release",
          {periph_busy, out_valid}, 0);

    // R1: first data byte carries channel 0
    send(0, 8'h42, 1);

    // table walk with R4 R5 R6 R7 R8 covered; stalls exercise R9 R10
    ready_mode = 1;
    for (int i = 0; i < NV; i++) send(VEC[i][8], VEC[i][7:0], 1);
    ready_mode = 0;
    repeat (5) @(negedge clk);
    check(rd_idx == wr_idx, "R6 R7 R8", "beat count", rd_idx, wr_idx);

    // R9 R10: stalled output holds busy and the beat
    ready_mode = 2;
    send(1, 8'h03, 1);
    send(0, 8'h99, 0);
    repeat (4) @(negedge clk);
    held = out_data;
    repeat (30) @(negedge clk);
    check(periph_busy == 1, "R10", "busy during stall", periph_busy, 1);
    check(out_valid == 1 && out_data == held && held == 8'h99, "R9",
          "held beat", {out_valid, out_data}, {1'b1, 8'h99});
    ready_mode = 0;
    repeat (20) @(negedge clk);
    check(periph_busy == 0, "R10", "busy after drain", periph_busy, 0);
    check(rd_idx == wr_idx, "R6", "stall beat count", rd_idx, wr_idx);

    // R6: count consumed, next data byte once
    send(0, 8'h13, 1);
    repeat (5) @(negedge clk);
    check(rd_idx == wr_idx, "R6", "count cleared", rd_idx, wr_idx);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule